// File: doc/BRIEF.md
# Register Protection Operand Checker

This block sits between instruction decode and execute. It examines the general-purpose register operands of one decoded instruction and decides whether the instruction may run. Each operand slot has a valid bit, an index, and a form bit. The form bit says whether the index came from a narrow 4-bit field or a wide 8-bit field. Every named register is compared against two bounds: the number of registers built into the hardware, and the enabled-register limit that system software programs into the flags control register.

When an operand names a register that does not exist in hardware, the block reports an unimplemented-register cause. When the register exists but lies above the enabled limit, it reports a protected-register cause. Either fault blocks execution. Only operands that are explicitly encoded and marked valid take part. The verdict is registered, so it appears one cycle after the request is presented. The verdict also gives the slot of the operand that caused the reported fault.

Top module: `regprot_checker`

## Requirements
- R1: A request on `chk_valid_i` produces `res_valid_o` high exactly one clock later, and `allow_o`, `cause_o` and `fault_slot_o` in that cycle describe that request.
- R2: When an operand's form bit is 0 (narrow), only index bits [3:0] are used, and bits [7:4] have no effect on the verdict.
- R3: When an operand's form bit is 1 (wide), all 8 index bits are used, so indices up to 255 can be named.
- R4: A valid operand whose index is greater than or equal to `impl_cnt_i` blocks execution with cause code 2'd1 (unimplemented).
- R5: A valid operand whose index is below `impl_cnt_i` but greater than or equal to the effective limit blocks execution with cause code 2'd2 (protected).
- R6: The effective limit is the smaller of `en_limit_i` and `impl_cnt_i`, so a limit above the implemented count never makes a missing register usable.
- R7: A limit of zero makes every implemented register protected.
- R8: An operand slot whose valid bit is 0 is ignored, whatever its index and form.
- R9: If any operand is unimplemented, the cause is unimplemented, even when another operand is protected.
- R10: `fault_slot_o` gives the lowest-numbered slot that has the reported cause. It is 0 when execution is allowed.
- R11: A request with no valid operands is allowed with cause code 2'd0 (none).
- R12: After reset, `res_valid_o` and `allow_o` are 0, `cause_o` is 2'd0 and `fault_slot_o` is 0.
- R13: In any cycle where `res_valid_o` is 0, `allow_o` is 0 and `cause_o` is 2'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_valid_i | input | 1 | A decoded instruction is presented for checking |
| opnd_vld_i | input | NUM_OPS | Per-slot operand valid bits |
| opnd_wide_i | input | NUM_OPS | Per-slot form bit: 1 = 8-bit field, 0 = 4-bit field |
| opnd_idx_i | input | NUM_OPS*IDX_W | Operand indices; slot k occupies bits [k*IDX_W +: IDX_W] |
| impl_cnt_i | input | IDX_W+1 | Number of registers implemented in hardware |
| en_limit_i | input | IDX_W+1 | Enabled-register limit from the flags control register |
| res_valid_o | output | 1 | Verdict valid for the request of the previous cycle |
| allow_o | output | 1 | Instruction may execute |
| cause_o | output | 2 | 0 none, 1 unimplemented register, 2 protected register |
| fault_slot_o | output | SLOT_W | Slot responsible for the reported cause |

## Verification
The assertions assume that `impl_cnt_i` never exceeds 2^IDX_W. They also assume that all inputs settle between clock edges, so that each verdict depends only on the values present at the capturing edge. The bench changes inputs only on falling edges and keeps the implemented count within 0..256. It still drives enabled limits above the implemented count on purpose, to exercise the clamp. Back-to-back requests alternate with idle gaps, so the one-cycle verdict and the quiet idle outputs are both checked.

// File: rtl/regprot_pkg.sv
package regprot_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_UNIMPL = 2'd1,
    CAUSE_PROT   = 2'd2
  } cause_e;
endpackage

// File: rtl/regprot_limit.sv
module regprot_limit #(
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] impl_cnt_i,
  input  logic [CNT_W-1:0] en_limit_i,
  output logic [CNT_W-1:0] eff_limit_o
);
  // the protection limit can only shrink the implemented range
  always_comb begin
    eff_limit_o = (en_limit_i < impl_cnt_i) ? en_limit_i : impl_cnt_i;
  end
endmodule

// File: rtl/regprot_opnd_chk.sv
module regprot_opnd_chk #(
  parameter int IDX_W    = 8,
  parameter int NARROW_W = 4,
  parameter int CNT_W    = IDX_W + 1
) (
  input  logic             vld_i,
  input  logic             wide_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] impl_cnt_i,
  input  logic [CNT_W-1:0] eff_limit_i,
  output logic             unimpl_o,
  output logic             prot_o
);
  localparam int PAD_W = CNT_W - NARROW_W;

  logic [CNT_W-1:0] reg_num;

  always_comb begin
    if (wide_i) reg_num = {{(CNT_W-IDX_W){1'b0}}, idx_i};
    else        reg_num = {{PAD_W{1'b0}}, idx_i[NARROW_W-1:0]};
  end

  always_comb begin
    unimpl_o = vld_i && (reg_num >= impl_cnt_i);
    prot_o   = vld_i && !unimpl_o && (reg_num >= eff_limit_i);
  end
endmodule

// File: rtl/regprot_merge.sv
module regprot_merge
  import regprot_pkg::*;
#(
  parameter int NUM_OPS = 3,
  parameter int SLOT_W  = 2
) (
  input  logic [NUM_OPS-1:0] unimpl_i,
  input  logic [NUM_OPS-1:0] prot_i,
  output cause_e             cause_o,
  output logic [SLOT_W-1:0]  slot_o
);
  logic [SLOT_W-1:0] unimpl_slot;
  logic [SLOT_W-1:0] prot_slot;

  // descending scan leaves the lowest hit
  always_comb begin
    unimpl_slot = '0;
    prot_slot   = '0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (unimpl_i[i]) unimpl_slot = SLOT_W'(i);
      if (prot_i[i])   prot_slot   = SLOT_W'(i);
    end
  end

  always_comb begin
    if (|unimpl_i) begin
      cause_o = CAUSE_UNIMPL;
      slot_o  = unimpl_slot;
    end else if (|prot_i) begin
      cause_o = CAUSE_PROT;
      slot_o  = prot_slot;
    end else begin
      cause_o = CAUSE_NONE;
      slot_o  = '0;
    end
  end
endmodule

// File: rtl/regprot_checker.sv
module regprot_checker
  import regprot_pkg::*;
#(
  parameter int NUM_OPS  = 3,
  parameter int IDX_W    = 8,
  parameter int NARROW_W = 4,
  localparam int CNT_W   = IDX_W + 1,
  localparam int SLOT_W  = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     chk_valid_i,
  input  logic [NUM_OPS-1:0]       opnd_vld_i,
  input  logic [NUM_OPS-1:0]       opnd_wide_i,
  input  logic [NUM_OPS*IDX_W-1:0] opnd_idx_i,
  input  logic [CNT_W-1:0]         impl_cnt_i,
  input  logic [CNT_W-1:0]         en_limit_i,
  output logic                     res_valid_o,
  output logic                     allow_o,
  output logic [1:0]               cause_o,
  output logic [SLOT_W-1:0]        fault_slot_o
);
  logic [CNT_W-1:0]   eff_limit;
  logic [NUM_OPS-1:0] unimpl_vec;
  logic [NUM_OPS-1:0] prot_vec;
  cause_e             cause_d;
  logic [SLOT_W-1:0]  slot_d;

  logic               valid_q;
  cause_e             cause_q;
  logic [SLOT_W-1:0]  slot_q;

  regprot_limit #(.CNT_W(CNT_W)) u_limit (
    .impl_cnt_i (impl_cnt_i),
    .en_limit_i (en_limit_i),
    .eff_limit_o(eff_limit)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    regprot_opnd_chk #(
      .IDX_W   (IDX_W),
      .NARROW_W(NARROW_W),
      .CNT_W   (CNT_W)
    ) u_chk (
      .vld_i      (opnd_vld_i[g]),
      .wide_i     (opnd_wide_i[g]),
      .idx_i      (opnd_idx_i[g*IDX_W +: IDX_W]),
      .impl_cnt_i (impl_cnt_i),
      .eff_limit_i(eff_limit),
      .unimpl_o   (unimpl_vec[g]),
      .prot_o     (prot_vec[g])
    );

    // R9: a slot never carries both fault kinds
    a_r9_excl_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(unimpl_vec[g] && prot_vec[g]));
  end

  regprot_merge #(.NUM_OPS(NUM_OPS), .SLOT_W(SLOT_W)) u_merge (
    .unimpl_i(unimpl_vec),
    .prot_i  (prot_vec),
    .cause_o (cause_d),
    .slot_o  (slot_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      slot_q  <= '0;
    end else begin
      valid_q <= chk_valid_i;
      cause_q <= chk_valid_i ? cause_d : CAUSE_NONE;
      slot_q  <= chk_valid_i ? slot_d  : '0;
    end
  end

  assign res_valid_o  = valid_q;
  assign allow_o      = valid_q && (cause_q == CAUSE_NONE);
  assign cause_o      = cause_q;
  assign fault_slot_o = slot_q;

  a_r1_verdict_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i |=> res_valid_o);

  a_r6_limit_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_limit <= impl_cnt_i) && (eff_limit <= en_limit_i));

  a_r10_slot_zero_on_allow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o |-> (fault_slot_o == '0) && (cause_o == 2'd0));

  a_r13_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !allow_o && (cause_o == 2'd0));

  a_r4_fault_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && cause_o != 2'd0) |-> !allow_o);

  a_r8_no_valid_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_vld_i == '0) |-> (unimpl_vec == '0) && (prot_vec == '0));
endmodule

// File: tb/regprot_checker_tb.sv
`timescale 1ns/1ps
module regprot_checker_tb;
  localparam int NUM_OPS = 3;
  localparam int IDX_W   = 8;
  localparam int CNT_W   = IDX_W + 1;
  localparam int SLOT_W  = 2;

  typedef struct {
    int              stamp;
    bit              allow;
    bit [1:0]        cause;
    bit [SLOT_W-1:0] slot;
    string           req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_valid = 1'b0;
  logic [NUM_OPS-1:0] vld = '0;
  logic [NUM_OPS-1:0] wide = '0;
  logic [NUM_OPS*IDX_W-1:0] idx = '0;
  logic [CNT_W-1:0] impl = 9'd16;
  logic [CNT_W-1:0] lim = 9'd16;
  logic res_valid, allow;
  logic [1:0] cause;
  logic [SLOT_W-1:0] slot;

  int checks = 0, errors = 0, cyc = 0;
  bit mon_en = 1'b0, done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  regprot_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chk_valid_i(chk_valid),
    .opnd_vld_i(vld), .opnd_wide_i(wide), .opnd_idx_i(idx),
    .impl_cnt_i(impl), .en_limit_i(lim),
    .res_valid_o(res_valid), .allow_o(allow), .cause_o(cause),
    .fault_slot_o(slot)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // spec model: 0 none, 1 unimplemented, 2 protected
  function automatic exp_t model(input int im, input int li, input bit [2:0] v,
                                 input bit [2:0] w, input int i0, input int i1,
                                 input int i2, input string req);
    exp_t e;
    int ids[3];
    int eff;
    int us, ps;
    ids[0] = i0; ids[1] = i1; ids[2] = i2;
    eff = (li < im) ? li : im;
    us = -1; ps = -1;
    for (int k = NUM_OPS - 1; k >= 0; k--) begin
      int n;
      if (!v[k]) continue;
      n = w[k] ? ids[k] : (ids[k] % 16);
      if (n >= im) us = k;
      else if (n >= eff) ps = k;
    end
    e.req = req;
    e.stamp = 0;
    if (us >= 0) begin e.allow = 0; e.cause = 2'd1; e.slot = SLOT_W'(us); end
    else if (ps >= 0) begin e.allow = 0; e.cause = 2'd2; e.slot = SLOT_W'(ps); end
    else begin e.allow = 1; e.cause = 2'd0; e.slot = '0; end
    return e;
  endfunction

  task automatic issue(input int im, input int li, input bit [2:0] v,
                       input bit [2:0] w, input int i0, input int i1,
                       input int i2, input string req);
    exp_t e;
    @(negedge clk);
    e = model(im, li, v, w, i0, i1, i2, req);
    e.stamp = cyc;
    chk_valid = 1'b1;
    impl = CNT_W'(im); lim = CNT_W'(li);
    vld = v; wide = w;
    idx = {IDX_W'(i2), IDX_W'(i1), IDX_W'(i0)};
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk_valid = 1'b0;
      vld = 3'b111; wide = 3'b111; idx = '1; lim = '0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (q.size() > 0 && q[0].stamp == cyc - 1) begin
        exp_t e;
        e = q.pop_front();
        chk(res_valid === 1'b1, {e.req, " R1"}, "res_valid", int'(res_valid), 1);
        chk(allow === e.allow, e.req, "allow", int'(allow), int'(e.allow));
        chk(cause === e.cause, e.req, "cause", int'(cause), int'(e.cause));
        chk(slot === e.slot, {e.req, " R10"}, "slot", int'(slot), int'(e.slot));
      end else begin
        chk(res_valid === 1'b0, "R13", "idle res_valid", int'(res_valid), 0);
        chk(allow === 1'b0 && cause === 2'd0, "R13", "idle allow/cause",
            int'({allow, cause}), 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid === 1'b0, "R12", "reset res_valid", int'(res_valid), 0);
    chk(allow === 1'b0, "R12", "reset allow", int'(allow), 0);
    chk(cause === 2'd0, "R12", "reset cause", int'(cause), 0);
    chk(slot === '0, "R12", "reset slot", int'(slot), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;

    issue(16, 16, 3'b111, 3'b000, 1, 5, 15, "R1 main");
    issue(16, 16, 3'b001, 3'b000, 8'hF3, 0, 0, "R2 narrow upper ignored");
    issue(16, 4, 3'b001, 3'b000, 8'hF3, 0, 0, "R2 narrow upper ignored");
    issue(16, 16, 3'b010, 3'b010, 0, 8'h20, 0, "R3 R4 wide unimpl");
    issue(16, 16, 3'b011, 3'b011, 15, 16, 0, "R4 boundary");
    issue(256, 256, 3'b001, 3'b001, 255, 0, 0, "R3 top index");
    idle(2);
    issue(16, 8, 3'b001, 3'b000, 8, 0, 0, "R5 protected");
    issue(16, 8, 3'b001, 3'b000, 7, 0, 0, "R5 below limit");
    issue(16, 40, 3'b100, 3'b100, 0, 0, 20, "R6 clamp unimpl");
    issue(64, 40, 3'b011, 3'b011, 39, 40, 0, "R6 limit under impl");
    issue(16, 0, 3'b001, 3'b000, 0, 0, 0, "R7 zero limit");
    issue(0, 0, 3'b001, 3'b000, 0, 0, 0, "R4 zero impl");
    idle(1);
    issue(16, 16, 3'b011, 3'b100, 2, 3, 200, "R8 invalid slot");
    issue(16, 4, 3'b101, 3'b100, 9, 0, 30, "R9 unimpl over prot");
    issue(16, 4, 3'b110, 3'b000, 0, 6, 7, "R10 lowest prot");
    issue(16, 16, 3'b111, 3'b111, 40, 50, 60, "R10 lowest unimpl");
    issue(16, 0, 3'b000, 3'b111, 255, 255, 255, "R11 no operands");
    idle(3);
    chk(q.size() == 0, "R1", "pending", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule